// File: doc/BRIEF.md
# Segmented DAC input decoder

This block is the digital front end of a current-steering digital-to-analog converter that uses a split architecture. Each clock it accepts a parallel binary sample and a complement control. When the complement control is high, the sample is bit-inverted first. The resulting word is then split in two. The low field goes out unchanged as binary-weighted switch controls. The four-bit high field is expanded into a thermometer code of fifteen enables, one per identical unit current source.

All switch controls come from a single output register and change on the same rising clock edge. Input skew and unequal decode delays therefore never reach the current switches. A parameter selects the word width: 10 bits, with a 6-bit binary field, or 8 bits, with a 4-bit binary field. The high field is four bits in both cases.

A combinational level output reconstructs the code from the registered controls: the number of active enables times the weight of one unit, plus the binary field. Integration checks use it to confirm that the decoded output is monotonic.

Top module: `seg_dac_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every output bit is zero on the following cycle, whatever `code_in` and `invert_in` are.
- R2: `lsb_out` equals the low `DATA_W-4` bits of the decoded word, one cycle after the sample. The decoded word is `code_in` when `invert_in` is 0 and `~code_in` when it is 1.
- R3: For a decoded high field of value n (bits `DATA_W-1` down to `DATA_W-4`), `unit_en_out[k]` is 1 exactly for k < n. Bit k drives unit source k+1. For example, high field 0110 gives `unit_en_out = 15'h003F`.
- R4: A high field with only its top bit set (value 8) enables exactly eight unit sources: `unit_en_out = 15'h00FF`.
- R5: Outputs change only at a rising edge and reflect the inputs sampled at that edge. Input changes between edges leave the outputs unchanged.
- R6: With `invert_in = 1`, every bit of the sample is inverted before the split. For example, code 0 gives all fifteen enables on and `lsb_out` all ones.
- R7: `level_out` equals `popcount(unit_en_out) * 2^(DATA_W-4) + lsb_out`. This equals the decoded word of the previous sample, so stepping the input through every code in increasing order raises `level_out` by exactly one per step.
- R8: With `DATA_W = 8`, the same rules apply with a 4-bit `lsb_out`, fifteen enables and an 8-bit `level_out`.
- R9: At 10 bits, the step from 0x01F to 0x3E0 toggles all 15 enables and all 6 binary controls. The mid-scale step from 0x1FF to 0x200 toggles exactly one enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | DATA_W | Binary input sample |
| invert_in | input | 1 | 1 = invert the sample before decoding |
| lsb_out | output | DATA_W-4 | Registered binary-weighted controls |
| unit_en_out | output | 15 | Registered unit-source enables, bit k = source k+1 |
| level_out | output | DATA_W | Code reconstructed from the registered controls |

## Verification
The bench builds two instances side by side, one with `DATA_W = 10` and one with `DATA_W = 8`, and drives both from the same stimulus. The 10-bit build is small enough for an exhaustive ascending sweep of all 1024 codes, which makes the monotonic-level property checkable code by code. The same build also exercises the two named switching transitions. The 8-bit build shows that the narrower binary field still leaves the thermometer expansion and the inversion intact under random samples.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
   // Width of the thermometer-coded upper field
   localparam int SEG_W = 4;
   // Number of identical unit sources driven by the upper field
   localparam int UNITS = (1 << SEG_W) - 1;
   // Width of a count of active units
   localparam int CNT_W = SEG_W;

   typedef logic [UNITS-1:0] unit_vec_t;
endpackage

// File: rtl/seg_dac_polarity.sv
module seg_dac_polarity #(
   parameter int W = 10
) (
   input  logic [W-1:0] word_i,
   input  logic         flip_i,
   output logic [W-1:0] word_o
);
   // One XOR per bit keeps every bit on an equal-depth path
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign word_o[b] = word_i[b] ^ flip_i;
   end
endmodule

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
   parameter int SW = 4,
   localparam int NU = (1 << SW) - 1
) (
   input  logic [SW-1:0] seg_i,
   output logic [NU-1:0] en_o
);
   // Unit k is on when the field value exceeds k; the result is contiguous from unit 0
   for (genvar k = 0; k < NU; k++) begin : g_unit
      assign en_o[k] = (seg_i > SW'(k));
   end
endmodule

// File: rtl/seg_dac_outreg.sv
module seg_dac_outreg #(
   parameter int LW = 6,
   parameter int NU = 15
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [LW-1:0] lsb_d,
   input  logic [NU-1:0] unit_d,
   output logic [LW-1:0] lsb_q,
   output logic [NU-1:0] unit_q
);
   // Single register stage: every switch control changes on the same edge
   always_ff @(posedge clk) begin
      if (rst) begin
         lsb_q  <= '0;
         unit_q <= '0;
      end else begin
         lsb_q  <= lsb_d;
         unit_q <= unit_d;
      end
   end
endmodule

// File: rtl/seg_dac_level.sv
module seg_dac_level #(
   parameter int LW = 6,
   parameter int NU = 15,
   parameter int CW = 4,
   localparam int OW = CW + LW
) (
   input  logic [LW-1:0] lsb_i,
   input  logic [NU-1:0] unit_i,
   output logic [OW-1:0] level_o
);
   logic [CW-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NU; k++) begin
         cnt = cnt + CW'(unit_i[k]);
      end
   end

   // Unit count carries weight 2^LW, so it lands directly above the binary field
   assign level_o = {cnt, lsb_i};
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
   import seg_dac_pkg::*;
#(
   parameter int DATA_W = 10,
   localparam int LSB_W = DATA_W - SEG_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] code_in,
   input  logic              invert_in,
   output logic [LSB_W-1:0]  lsb_out,
   output logic [UNITS-1:0]  unit_en_out,
   output logic [DATA_W-1:0] level_out
);
   initial begin
      if (!(DATA_W == 10 || DATA_W == 8)) begin
         $error("seg_dac_decoder: DATA_W must be 8 or 10");
      end
      if (LSB_W + SEG_W != DATA_W) begin
         $error("seg_dac_decoder: field split does not cover the word");
      end
   end

   logic [DATA_W-1:0] word;
   logic [SEG_W-1:0]  seg_field;
   logic [LSB_W-1:0]  lsb_field;
   unit_vec_t         unit_d;

   seg_dac_polarity #(.W(DATA_W)) u_pol (
      .word_i (code_in),
      .flip_i (invert_in),
      .word_o (word)
   );

   assign seg_field = word[DATA_W-1 -: SEG_W];
   assign lsb_field = word[LSB_W-1:0];

   seg_dac_therm #(.SW(SEG_W)) u_therm (
      .seg_i (seg_field),
      .en_o  (unit_d)
   );

   seg_dac_outreg #(.LW(LSB_W), .NU(UNITS)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .lsb_d  (lsb_field),
      .unit_d (unit_d),
      .lsb_q  (lsb_out),
      .unit_q (unit_en_out)
   );

   seg_dac_level #(.LW(LSB_W), .NU(UNITS), .CW(CNT_W)) u_lvl (
      .lsb_i   (lsb_out),
      .unit_i  (unit_en_out),
      .level_o (level_out)
   );
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
   parameter int DATA_W = 10,
   localparam int LSB_W = DATA_W - 4,
   localparam int NU = 15
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] code_in,
   input logic              invert_in,
   input logic [LSB_W-1:0]  lsb_out,
   input logic [NU-1:0]     unit_en_out,
   input logic [DATA_W-1:0] level_out
);
   logic seen = 1'b0;
   always_ff @(posedge clk) seen <= 1'b1;

   // R1: reset leaves all controls at zero scale
   p_reset_zero_r1: assert property (@(posedge clk)
      (seen && $past(rst)) |-> (lsb_out == '0 && unit_en_out == '0));

   // R3: the enables always form a contiguous run starting at unit 1
   p_therm_contig_r3: assert property (@(posedge clk) disable iff (rst)
      (((unit_en_out + NU'(1)) & unit_en_out) == '0));

   // R2: the binary field follows the decoded sample one cycle later
   p_lsb_follow_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (lsb_out == LSB_W'($past(invert_in) ? ~$past(code_in) : $past(code_in))));

   // R7: the reconstructed level equals the decoded sample of the previous cycle
   p_level_match_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (level_out == ($past(invert_in) ? ~$past(code_in) : $past(code_in))));

   // R3: the number of active enables equals the decoded upper field
   p_unit_count_r3: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ($countones(unit_en_out) ==
                int'(4'(($past(invert_in) ? ~$past(code_in) : $past(code_in)) >> LSB_W))));
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .code_in     (code_in),
   .invert_in   (invert_in),
   .lsb_out     (lsb_out),
   .unit_en_out (unit_en_out),
   .level_out   (level_out)
);

// File: tb/seg_dac_decoder_bench.sv
module seg_dac_decoder_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [9:0]  code10 = '0;
   logic [7:0]  code8  = '0;
   logic        inv    = 1'b0;
   logic [5:0]  lsb10;
   logic [3:0]  lsb8;
   logic [14:0] en10, en8;
   logic [9:0]  lvl10;
   logic [7:0]  lvl8;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   seg_dac_decoder #(.DATA_W(10)) u_seg_dac_decoder (
      .clk(clk), .rst(rst), .code_in(code10), .invert_in(inv),
      .lsb_out(lsb10), .unit_en_out(en10), .level_out(lvl10));

   seg_dac_decoder #(.DATA_W(8)) u_seg_dac_decoder_w8 (
      .clk(clk), .rst(rst), .code_in(code8), .invert_in(inv),
      .lsb_out(lsb8), .unit_en_out(en8), .level_out(lvl8));

   function automatic logic [14:0] therm(input int n);
      return 15'((32'd1 << n) - 1);
   endfunction

   function automatic int ones(input logic [31:0] v);
      int c = 0;
      for (int i = 0; i < 32; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [9:0] c, input logic i);
      @(negedge clk);
      code10 = c;
      code8  = c[7:0];
      inv    = i;
      @(posedge clk);
      #1;
   endtask

   task automatic check_both(input string req);
      logic [9:0] w10;
      logic [7:0] w8;
      w10 = inv ? ~code10 : code10;
      w8  = inv ? ~code8  : code8;
      chk({req, " lsb10"}, 32'(lsb10), 32'(w10[5:0]));
      chk({req, " en10"},  32'(en10),  32'(therm(int'(w10[9:6]))));
      chk({req, " lvl10"}, 32'(lvl10), 32'(w10));
      chk({req, " R8 lsb8"}, 32'(lsb8), 32'(w8[3:0]));
      chk({req, " R8 en8"},  32'(en8),  32'(therm(int'(w8[7:4]))));
      chk({req, " R8 lvl8"}, 32'(lvl8), 32'(w8));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [14:0] e0;
      logic [5:0]  l0;
      logic [9:0]  prev;
      void'($urandom(32'd1234));

      // R1: reset dominates nonzero inputs
      @(negedge clk);
      code10 = 10'h3FF; code8 = 8'hFF; inv = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 en10", 32'(en10), 0);
      chk("R1 lsb10", 32'(lsb10), 0);
      chk("R1 en8", 32'(en8), 0);
      chk("R1 lvl10", 32'(lvl10), 0);
      @(negedge clk);
      rst = 1'b0;

      // R3: upper field 0110 enables units 1..6
      apply(10'h180, 1'b0);
      chk("R3 en10 0110", 32'(en10), 32'h003F);
      check_both("R3");
      // R4: top upper bit alone gives eight units
      apply(10'h200, 1'b0);
      chk("R4 en10 1000", 32'(en10), 32'h00FF);
      apply(10'h3FF, 1'b0);
      check_both("R3 full");
      apply(10'h000, 1'b0);
      check_both("R3 zero");

      // R6: inversion
      apply(10'h000, 1'b1);
      chk("R6 en10", 32'(en10), 32'h7FFF);
      chk("R6 lsb10", 32'(lsb10), 32'h3F);
      apply(10'h2A5, 1'b1);
      check_both("R6");

      // R5: mid-cycle input changes do not move outputs
      apply(10'h155, 1'b0);
      @(negedge clk);
      code10 = 10'h2AA; code8 = 8'hAA; inv = 1'b1;
      #2;
      chk("R5 hold en10", 32'(en10), 32'(therm(5)));
      chk("R5 hold lsb10", 32'(lsb10), 32'h15);
      chk("R5 hold lvl10", 32'(lvl10), 32'h155);
      @(posedge clk);
      #1;
      check_both("R5 update");

      // R9: worst-case and mid-scale transitions
      apply(10'h01F, 1'b0);
      e0 = en10; l0 = lsb10;
      apply(10'h3E0, 1'b0);
      chk("R9 worst en toggles", 32'(ones(32'(e0 ^ en10))), 15);
      chk("R9 worst lsb toggles", 32'(ones(32'(l0 ^ lsb10))), 6);
      apply(10'h1FF, 1'b0);
      e0 = en10; l0 = lsb10;
      apply(10'h200, 1'b0);
      chk("R9 mid en toggles", 32'(ones(32'(e0 ^ en10))), 1);
      chk("R9 mid lsb toggles", 32'(ones(32'(l0 ^ lsb10))), 6);

      // R7: ascending sweep, level rises by one per code
      apply(10'h000, 1'b0);
      prev = lvl10;
      chk("R7 sweep start", 32'(lvl10), 0);
      for (int c = 1; c < 1024; c++) begin
         apply(10'(c), 1'b0);
         chk("R7 step", 32'(lvl10), 32'(prev) + 1);
         chk("R3 sweep en", 32'(en10), 32'(therm(c >> 6)));
         prev = lvl10;
      end

      // R2 R6 R8: random samples on both widths
      for (int n = 0; n < 400; n++) begin
         apply(10'($urandom), 1'($urandom));
         check_both("R2 rand");
      end

      // R1: reset mid-run returns to zero scale
      @(negedge clk);
      rst = 1'b1; code10 = 10'h3C3; inv = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 late en10", 32'(en10), 0);
      chk("R1 late lsb8", 32'(lsb8), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule